// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the digital feedback divider of a fractional-N synthesizer loop. It counts cycles of the divided-VCO clock against a 16-bit integer ratio and emits one single-cycle pulse per divider period toward the phase detector. At every period boundary a 3-bit phase accumulator adds a programmable fractional step. The accumulator wraps at either 8 or 5, as selected by a modulus bit. A wrap lengthens the following period by one input cycle, so the long-run division ratio is the integer ratio plus step/modulus. The accumulator value is presented on a port after every boundary, so that neighbouring logic can scale a compensation current from it.

New settings are written into a pending set at any time. They move into the working set only at a period boundary, or at the first enabled edge after a restart, so the output phase never jumps mid-period. A one-cycle sync pulse marks each such transfer. While the enable is low the count and the accumulator are held at zero and no pulses leave the block. Raising the enable starts a fresh period from a known phase.

Top module: `frac_main_div`

## Requirements
- R1: While `en` is low (and during reset) `div_pulse`, `sync_pulse` and `frac_acc` are all 0 from the next clock edge on.
- R2: With no accumulator wrap, consecutive `div_pulse` assertions are exactly NMAIN clock cycles apart, where NMAIN is the working integer ratio (reset value 512).
- R3: With modulus bit 0 (modulus 8), at each pulse `frac_acc` becomes (previous + step) mod 8. When the sum reaches 8 or more, the next period lasts NMAIN+1 cycles.
- R4: With modulus bit 1 (modulus 5), at each pulse `frac_acc` becomes (previous + step) mod 5 and stays below 5. When the sum reaches 5 or more, the next period lasts NMAIN+1 cycles.
- R5: With fixed settings, any Q consecutive periods (Q being the modulus) total Q*NMAIN + step cycles.
- R6: A write on `cfg_wr` only updates the pending set. The working set changes only at a period boundary or at a restart. The period in progress keeps its old length. `sync_pulse` is high for one cycle, together with the `div_pulse` of the boundary that applied the new set, and is low at every other boundary.
- R7: A written ratio below 512 is stored as 512.
- R8: With modulus bit 1, a written step above 4 is stored as 4.
- R9: When an applied set changes the modulus, the accumulator is cleared at that boundary. The wrap decision of that boundary, computed with the old settings, still lengthens the next period.
- R10: On the first clock edge that samples `en` high after it was low, a new period starts and any pending set is applied, with `sync_pulse` high alone in the following cycle. The first `div_pulse` follows NMAIN edges after that edge.
- R11: `div_pulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Divider power/enable; low holds the block idle |
| cfg_wr | input | 1 | Writes the three settings below into the pending set |
| cfg_ratio | input | 16 | Integer ratio NMAIN (512 to 65535) |
| cfg_frac | input | 3 | Fractional step per period |
| cfg_mod5 | input | 1 | Modulus select: 0 = modulo 8, 1 = modulo 5 |
| div_pulse | output | 1 | One-cycle pulse at the end of every divider period |
| sync_pulse | output | 1 | One-cycle pulse when the pending set enters the working set |
| frac_acc | output | 3 | Accumulator value after the latest boundary |

## Verification
The hardest situation to reach is a boundary where a new set that changes the modulus is applied on the same edge as an accumulator wrap. The clear of the accumulator and the stretch from the old settings then act at once. The stimulus reaches it by writing each new set right after a pulse, while the accumulator holds a known nonzero value, and by stepping through modulo-8, modulo-5 and clamped settings in turn. Random settings then repeat that case many times against a period-by-period prediction. A write made while the divider is disabled exercises the restart path, where the set is applied with no boundary pulse.

// File: rtl/frac_div_pkg.sv
// Shared widths and the settings record for the fractional-N divider.
// Assumes a 16-bit integer ratio and a 3-bit fractional step.
package frac_div_pkg;
    localparam int DIV_W  = 16;
    localparam int FRAC_W = 3;

    typedef struct packed {
        logic              mod5;
        logic [FRAC_W-1:0] nf;
        logic [DIV_W-1:0]  nmain;
    } div_cfg_t;
endpackage

// File: rtl/frac_div_cfg.sv
// Pending and working settings for the divider.
// Writes are cleaned (ratio floor, step clamp for the short modulus) and held
// as pending. They move into the working set when 'apply' is high.
// Assumes ALT_MOD <= 2**FRAC_W and MIN_RATIO fits in DIV_W bits.
module frac_div_cfg
    import frac_div_pkg::*;
#(
    parameter int MIN_RATIO = 512,
    parameter int RST_RATIO = 512,
    parameter int ALT_MOD   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DIV_W-1:0]  wr_nmain,
    input  logic [FRAC_W-1:0] wr_nf,
    input  logic              wr_mod5,
    input  logic              apply,
    output div_cfg_t          work,
    output div_cfg_t          next_cfg,
    output logic              applied,
    output logic              mod_change
);
    localparam logic [DIV_W-1:0]  MIN_R   = DIV_W'(MIN_RATIO);
    localparam logic [FRAC_W-1:0] ALT_MAX = FRAC_W'(ALT_MOD - 1);
    localparam div_cfg_t          RST_CFG = '{mod5: 1'b0, nf: '0, nmain: DIV_W'(RST_RATIO)};

    div_cfg_t pend_q;
    div_cfg_t work_q;
    div_cfg_t wr_clean;
    logic     pend_v_q;

    // Clean a written set: raise short ratios, cap steps the short modulus cannot take.
    always_comb begin
        wr_clean.mod5  = wr_mod5;
        wr_clean.nmain = (wr_nmain < MIN_R) ? MIN_R : wr_nmain;
        wr_clean.nf    = (wr_mod5 && (wr_nf > ALT_MAX)) ? ALT_MAX : wr_nf;
    end

    assign applied    = apply & pend_v_q;
    assign next_cfg   = applied ? pend_q : work_q;
    assign mod_change = applied && (pend_q.mod5 != work_q.mod5);
    assign work       = work_q;

    // Capture writes into the pending set and track whether one is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= RST_CFG;
            pend_v_q <= 1'b0;
        end else if (wr) begin
            pend_q   <= wr_clean;
            pend_v_q <= 1'b1;
        end else if (applied) begin
            pend_v_q <= 1'b0;
        end
    end

    // Move the pending set into the working set only on an allowed edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= RST_CFG;
        end else if (applied) begin
            work_q <= pend_q;
        end
    end
endmodule

// File: rtl/frac_div_accum.sv
// Fractional phase accumulator with a selectable wrap value.
// Adds the step once per period boundary and reports a wrap for the next period.
// Assumes step < modulus (guaranteed by the settings block).
module frac_div_accum
    import frac_div_pkg::*;
#(
    parameter int ALT_MOD = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              wipe,
    input  logic [FRAC_W-1:0] nf,
    input  logic              mod5,
    output logic [FRAC_W-1:0] acc,
    output logic              ovf
);
    localparam int SUM_W    = FRAC_W + 1;
    localparam int BASE_MOD = 1 << FRAC_W;

    logic [FRAC_W-1:0] acc_q;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  q;
    logic [SUM_W-1:0]  wrapped;
    logic              reach;

    // Sum, wrap test and wrapped value for the active modulus.
    always_comb begin
        q       = mod5 ? SUM_W'(ALT_MOD) : SUM_W'(BASE_MOD);
        sum     = {1'b0, acc_q} + {1'b0, nf};
        reach   = (sum >= q);
        wrapped = reach ? (sum - q) : sum;
    end

    assign ovf = step & reach;
    assign acc = acc_q;

    // Update the accumulator at each boundary; zero it while idle or on a modulus switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= wipe ? '0 : wrapped[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/frac_div_counter.sv
// Down counter that sets the divider period.
// Starts a period on the first enabled edge, flags terminal count at zero and
// reloads with ratio-1 plus the one-cycle stretch. Assumes ratio >= 2.
module frac_div_counter
    import frac_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] ratio,
    input  logic             extra,
    output logic             start,
    output logic             tc,
    output logic             running
);
    logic [DIV_W-1:0] cnt_q;
    logic             run_q;
    logic [DIV_W-1:0] reload;

    assign start   = en & ~run_q;
    assign tc      = en & run_q & (cnt_q == '0);
    assign running = run_q;
    assign reload  = ratio - DIV_W'(1) + DIV_W'(extra);

    // Count down through each period; hold at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= ratio - DIV_W'(1);
        end else if (tc) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end
endmodule

// File: rtl/frac_main_div.sv
// Fractional-N feedback divider top level.
// Ties the settings, counter and accumulator together and registers the
// boundary and sync pulses. Assumes the ratio is held at 512 or more by the settings block.
module frac_main_div
    import frac_div_pkg::*;
#(
    parameter int MIN_RATIO = 512,
    parameter int RST_RATIO = 512,
    parameter int ALT_MOD   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_ratio,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              cfg_mod5,
    output logic              div_pulse,
    output logic              sync_pulse,
    output logic [FRAC_W-1:0] frac_acc
);
    div_cfg_t          work;
    div_cfg_t          next_cfg;
    logic              applied;
    logic              mod_change;
    logic              start;
    logic              tc;
    logic              running;
    logic              ovf;
    logic [FRAC_W-1:0] acc;

    frac_div_cfg #(
        .MIN_RATIO (MIN_RATIO),
        .RST_RATIO (RST_RATIO),
        .ALT_MOD   (ALT_MOD)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .wr_nmain   (cfg_ratio),
        .wr_nf      (cfg_frac),
        .wr_mod5    (cfg_mod5),
        .apply      (start | tc),
        .work       (work),
        .next_cfg   (next_cfg),
        .applied    (applied),
        .mod_change (mod_change)
    );

    frac_div_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ratio   (next_cfg.nmain),
        .extra   (ovf),
        .start   (start),
        .tc      (tc),
        .running (running)
    );

    frac_div_accum #(
        .ALT_MOD (ALT_MOD)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~en),
        .step  (tc),
        .wipe  (mod_change),
        .nf    (work.nf),
        .mod5  (work.mod5),
        .acc   (acc),
        .ovf   (ovf)
    );

    assign frac_acc = acc;

    // Register the boundary pulse and the settings-transfer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_pulse  <= 1'b0;
            sync_pulse <= 1'b0;
        end else begin
            div_pulse  <= tc;
            sync_pulse <= applied;
        end
    end
endmodule

// File: rtl/frac_main_div_chk.sv
// Property checker for the fractional-N divider, bound into every instance.
// Watches the ports plus the working set and the counter's start/terminal flags.
module frac_main_div_chk
    import frac_div_pkg::*;
#(
    parameter int MIN_RATIO = 512,
    parameter int ALT_MOD   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              div_pulse,
    input logic              sync_pulse,
    input logic [FRAC_W-1:0] frac_acc,
    input div_cfg_t          work,
    input logic              start,
    input logic              tc
);
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!div_pulse && !sync_pulse && (frac_acc == '0)));

    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        work.mod5 |-> (frac_acc < FRAC_W'(ALT_MOD)));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tc) |=> $stable(work));

    assert_sync_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (div_pulse || $past(start)));

    assert_ratio_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        work.nmain >= DIV_W'(MIN_RATIO));

    assert_frac_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        work.mod5 |-> (work.nf <= FRAC_W'(ALT_MOD - 1)));

    assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !div_pulse);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
endmodule

bind frac_main_div frac_main_div_chk #(
    .MIN_RATIO (MIN_RATIO),
    .ALT_MOD   (ALT_MOD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div_pulse  (div_pulse),
    .sync_pulse (sync_pulse),
    .frac_acc   (frac_acc),
    .work       (work),
    .start      (start),
    .tc         (tc)
);

// File: tb/tb_frac_main_div.sv
`timescale 1ns/1ps
module tb_frac_main_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_ratio = '0;
    logic [2:0]  cfg_frac = '0;
    logic        cfg_mod5 = 1'b0;
    logic        div_pulse;
    logic        sync_pulse;
    logic [2:0]  frac_acc;

    int n_tests = 0;
    int n_fail  = 0;
    int ncyc    = 0;

    // bench view of the working and pending settings
    int b_n = 512, b_nf = 0, b_m5 = 0, b_acc = 0;
    int p_n = 512, p_nf = 0, p_m5 = 0, p_v = 0;
    int exp_per = 0, last_t = 0, have_last = 0;
    string exp_tag = "R2";
    string force_tag = "";

    frac_main_div dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr),
        .cfg_ratio(cfg_ratio), .cfg_frac(cfg_frac), .cfg_mod5(cfg_mod5),
        .div_pulse(div_pulse), .sync_pulse(sync_pulse), .frac_acc(frac_acc)
    );

    always #2.5 clk = ~clk;

    function automatic int clean_ratio(int n);
        return (n < 512) ? 512 : n;
    endfunction

    function automatic int clean_step(int nf, int m5);
        return (m5 != 0 && nf > 4) ? 4 : nf;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, ncyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ncyc++;
    endtask

    task automatic write_cfg(int n, int nf, int m5);
        cfg_wr    = 1'b1;
        cfg_ratio = 16'(n);
        cfg_frac  = 3'(nf);
        cfg_mod5  = m5[0];
        tick();
        cfg_wr = 1'b0;
        p_n  = clean_ratio(n);
        p_m5 = m5;
        p_nf = clean_step(nf, m5);
        p_v  = 1;
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 70000; i++) begin
            tick();
            if (div_pulse) break;
        end
    endtask

    // Check one boundary against the bench's own prediction.
    task automatic on_pulse();
        int q, sum, nacc, per;
        bit ov, ex_sync;
        string tg, ovtag;
        q     = (b_m5 != 0) ? 5 : 8;
        sum   = b_acc + b_nf;
        ov    = (sum >= q);
        nacc  = ov ? sum - q : sum;
        ovtag = (b_m5 != 0) ? "R4" : "R3";
        tg    = ovtag;
        if (have_last != 0) begin
            per = ncyc - last_t;
            chk(per == exp_per, (force_tag != "") ? force_tag : exp_tag, per, exp_per);
            force_tag = "";
        end
        ex_sync = (p_v != 0);
        if (p_v != 0) begin
            if (p_m5 != b_m5) begin
                nacc = 0;
                tg   = "R9";
            end
            b_n = p_n; b_nf = p_nf; b_m5 = p_m5; p_v = 0;
        end
        chk(int'(frac_acc) == nacc, tg, int'(frac_acc), nacc);
        chk(sync_pulse == ex_sync, "R6", int'(sync_pulse), int'(ex_sync));
        b_acc     = nacc;
        exp_per   = b_n + (ov ? 1 : 0);
        exp_tag   = ov ? ovtag : "R2";
        last_t    = ncyc;
        have_last = 1;
        tick();
        chk(!div_pulse, "R11", int'(div_pulse), 0);
    endtask

    task automatic observe(int k);
        for (int i = 0; i < k; i++) begin
            wait_pulse();
            on_pulse();
        end
    endtask

    // Q consecutive periods with steady settings must total Q*N + step.
    task automatic avg_check(string tag);
        int q, t0;
        observe(1);
        q  = (b_m5 != 0) ? 5 : 8;
        t0 = last_t;
        observe(q);
        chk((last_t - t0) == q * b_n + b_nf, tag, last_t - t0, q * b_n + b_nf);
    endtask

    task automatic restart(bit wr_pend, int n, int nf, int m5);
        int t0;
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!div_pulse && frac_acc == 3'd0 && !sync_pulse, "R1",
                int'({div_pulse, sync_pulse, frac_acc}), 0);
        end
        b_acc = 0;
        if (wr_pend) write_cfg(n, nf, m5);
        en = 1'b1;
        t0 = ncyc;
        tick();
        chk(!div_pulse, "R10", int'(div_pulse), 0);
        chk(sync_pulse == (p_v != 0), "R10", int'(sync_pulse), p_v);
        if (p_v != 0) begin
            b_n = p_n; b_nf = p_nf; b_m5 = p_m5; p_v = 0;
        end
        exp_per   = b_n + 1;
        exp_tag   = "R10";
        last_t    = t0;
        have_last = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // reset state
        for (int i = 0; i < 3; i++) tick();
        chk(!div_pulse && !sync_pulse && frac_acc == 3'd0, "R1",
            int'({div_pulse, sync_pulse, frac_acc}), 0);
        rst_n = 1'b1;
        tick();
        chk(!div_pulse && !sync_pulse && frac_acc == 3'd0, "R1",
            int'({div_pulse, sync_pulse, frac_acc}), 0);

        // R2/R10: reset ratio, no fraction
        restart(1'b0, 0, 0, 0);
        observe(3);

        // R6: write mid-run; current period keeps the old length. Then R3/R5.
        write_cfg(1000, 3, 0);
        force_tag = "R6";
        observe(10);
        avg_check("R5");

        // R4/R9: switch to modulus 5 while the accumulator holds a value
        write_cfg(777, 2, 1);
        observe(7);
        avg_check("R5");

        // R7/R8: short ratio and an oversized step under modulus 5
        write_cfg(100, 7, 1);
        observe(6);
        chk(b_n == 512 && b_nf == 4, "R7", b_n, 512);
        avg_check("R8");

        // back to modulus 8 with the largest step
        write_cfg(520, 7, 0);
        observe(6);
        avg_check("R3");

        // R10: settings written while disabled are applied at restart
        restart(1'b1, 600, 5, 0);
        observe(6);

        // random settings, written just after a boundary
        for (int k = 0; k < 10; k++) begin
            write_cfg(512 + int'($urandom % 128), int'($urandom % 8), int'($urandom % 2));
            observe(7);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule